// File: doc/BRIEF.md
# Fractional-Step Nanosecond Time-of-Day Counter

This block keeps a port's time of day as a 64-bit count of nanoseconds. On every clock edge, while counting is enabled, it adds a fixed-point step with 32 fractional bits. The fraction lives in a hidden 32-bit accumulator. Its carry moves into the nanosecond count, so a non-integer step such as 1.6 ns stays exact on average.

A four-way speed code selects a default step when `speed_apply` pulses. Three of the codes map to the 1.6 ns, 3.2 ns and 32 ns rates. The fourth code gives a step of zero, which stops the clock.

Software reaches the counter through a plain 32-bit register bus. Time and step each have a low word and a high word. Reading the low time word latches the whole value, so the two halves always belong together. Writes to the low words are only staged; the new 64-bit value lands when the matching high word is written. Software trims the frequency by writing a new step, and shifts the time by reading, adding and writing it back.

Top module: `tod_ns_counter`

## Requirements
- R1: After reset the time reads zero, the enable bit (register 0, bit 0) reads 0, and the step reads 0x00000001_99999999.
- R2: While enabled, each edge adds the step to the 96-bit value {time, fraction}. After k edges from a load, the time is T0 + floor(k*step / 2^32).
- R3: While the enable bit is clear, the time holds its value.
- R4: A `speed_apply` pulse loads the default step for `speed_sel`: code 0 gives 0x01_99999999, code 1 gives 0x03_33333333, code 2 gives 0x20_00000000, and code 3 gives zero.
- R5: With a step of zero, the time holds even while enabled.
- R6: A read of time-low (address 1) returns the low 32 bits and latches the upper 32 bits. A later read of time-high (address 2) returns those latched bits, even after the live time has moved on.
- R7: A write to time-low only stages the word. The time does not change until time-high is written.
- R8: A write to time-high loads {written word, staged low word} into the time and clears the fraction.
- R9: A write to step-low (address 3) only stages the word. A write to step-high (address 4) commits {written word, staged low word}. Both step words read back the active step.
- R10: When a time-high write and a step change happen on the same edge, both take effect, and the loaded time is not stepped on that edge.
- R11: When a step-high write and a `speed_apply` pulse happen on the same edge, the bus value wins.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Address 0 returns the enable bit in bit 0, and any address above 4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Link speed code used by `speed_apply` |
| speed_apply | input | 1 | Loads the default step for `speed_sel` |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tod_ns | output | 64 | Live nanosecond time |

## Verification
The bench builds the block with its default widths: 64-bit time, 32 fraction bits and a 32-bit bus. With 32 fraction bits, the expected time after k edges is one exact 128-bit product, so every count in the sweep can be checked against arithmetic. The sweep runs all four speed codes against twenty edge counts. It also drives the same-edge collisions, the latch across a 32-bit rollover, and a step chosen so that a leftover fraction would show up as an extra nanosecond.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

    localparam int unsigned TOD_ADDR_W = 3;

    // Register map
    localparam logic [TOD_ADDR_W-1:0] REG_CTRL    = 3'd0;
    localparam logic [TOD_ADDR_W-1:0] REG_TIME_LO = 3'd1;
    localparam logic [TOD_ADDR_W-1:0] REG_TIME_HI = 3'd2;
    localparam logic [TOD_ADDR_W-1:0] REG_STEP_LO = 3'd3;
    localparam logic [TOD_ADDR_W-1:0] REG_STEP_HI = 3'd4;

    // Speed codes
    localparam logic [1:0] SPD_FAST = 2'd0;
    localparam logic [1:0] SPD_MID  = 2'd1;
    localparam logic [1:0] SPD_SLOW = 2'd2;
    localparam logic [1:0] SPD_STOP = 2'd3;

    typedef struct packed {
        logic ctrl_wr;
        logic time_lo_wr;
        logic time_hi_wr;
        logic step_lo_wr;
        logic step_hi_wr;
        logic time_lo_rd;
    } tod_strobe_t;

endpackage

// File: rtl/tod_bus_dec.sv
`timescale 1ns/1ps
module tod_bus_dec
    import tod_pkg::*;
(
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [TOD_ADDR_W-1:0] bus_addr,
    output tod_strobe_t           strb
);
    always_comb begin
        strb            = '0;
        strb.ctrl_wr    = bus_wr && (bus_addr == REG_CTRL);
        strb.time_lo_wr = bus_wr && (bus_addr == REG_TIME_LO);
        strb.time_hi_wr = bus_wr && (bus_addr == REG_TIME_HI);
        strb.step_lo_wr = bus_wr && (bus_addr == REG_STEP_LO);
        strb.step_hi_wr = bus_wr && (bus_addr == REG_STEP_HI);
        strb.time_lo_rd = bus_rd && (bus_addr == REG_TIME_LO);
    end
endmodule

// File: rtl/tod_speed_step.sv
`timescale 1ns/1ps
module tod_speed_step
    import tod_pkg::*;
#(
    parameter int unsigned       STEP_W    = 64,
    parameter logic [STEP_W-1:0] STEP_FAST = 64'h0000_0001_9999_9999,
    parameter logic [STEP_W-1:0] STEP_MID  = 64'h0000_0003_3333_3333,
    parameter logic [STEP_W-1:0] STEP_SLOW = 64'h0000_0020_0000_0000
) (
    input  logic [1:0]        speed_sel,
    output logic [STEP_W-1:0] dflt_step
);
    always_comb begin
        unique case (speed_sel)
            SPD_MID:  dflt_step = STEP_MID;
            SPD_SLOW: dflt_step = STEP_SLOW;
            SPD_STOP: dflt_step = '0;
            default:  dflt_step = STEP_FAST;
        endcase
    end
endmodule

// File: rtl/tod_step_add.sv
`timescale 1ns/1ps
module tod_step_add #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned STEP_W = 64
) (
    input  logic [TIME_W-1:0] ns_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [TIME_W-1:0] ns_o,
    output logic [FRAC_W-1:0] frac_o
);
    localparam int unsigned ACC_W = TIME_W + FRAC_W;

    // Wraps at the top; a 64-bit nanosecond count does not overflow in service.
    always_comb begin
        {ns_o, frac_o} = {ns_i, frac_i} + ACC_W'(step_i);
    end
endmodule

// File: rtl/tod_ns_counter.sv
`timescale 1ns/1ps
module tod_ns_counter
    import tod_pkg::*;
#(
    parameter int unsigned       TIME_W    = 64,
    parameter int unsigned       FRAC_W    = 32,
    parameter int unsigned       BUS_W     = 32,
    parameter int unsigned       STEP_W    = 64,
    parameter logic [STEP_W-1:0] STEP_FAST = 64'h0000_0001_9999_9999,
    parameter logic [STEP_W-1:0] STEP_MID  = 64'h0000_0003_3333_3333,
    parameter logic [STEP_W-1:0] STEP_SLOW = 64'h0000_0020_0000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            speed_sel,
    input  logic                  speed_apply,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [TOD_ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic [TIME_W-1:0]     tod_ns
);
    localparam int unsigned TIME_HI_W = TIME_W - BUS_W;
    localparam int unsigned STEP_HI_W = STEP_W - BUS_W;

    typedef struct packed {
        logic [TIME_W-1:0]    ns;
        logic [FRAC_W-1:0]    frac;
        logic [STEP_W-1:0]    step;
        logic                 en;
        logic [BUS_W-1:0]     time_stage;
        logic [BUS_W-1:0]     step_stage;
        logic [TIME_HI_W-1:0] snap;
        logic [BUS_W-1:0]     rdata;
    } tod_state_t;

    localparam tod_state_t ST_RESET = '{
        ns: '0, frac: '0, step: STEP_FAST, en: 1'b0,
        time_stage: '0, step_stage: '0, snap: '0, rdata: '0
    };

    tod_state_t          st_d, st_q;
    tod_strobe_t         strb;
    logic [STEP_W-1:0]   dflt_step;
    logic [TIME_W-1:0]   step_ns;
    logic [FRAC_W-1:0]   step_frac;

    tod_bus_dec u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .strb     (strb)
    );

    tod_speed_step #(
        .STEP_W    (STEP_W),
        .STEP_FAST (STEP_FAST),
        .STEP_MID  (STEP_MID),
        .STEP_SLOW (STEP_SLOW)
    ) u_speed (
        .speed_sel (speed_sel),
        .dflt_step (dflt_step)
    );

    tod_step_add #(
        .TIME_W (TIME_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_add (
        .ns_i   (st_q.ns),
        .frac_i (st_q.frac),
        .step_i (st_q.step),
        .ns_o   (step_ns),
        .frac_o (step_frac)
    );

    always_comb begin
        st_d = st_q;

        if (strb.ctrl_wr)    st_d.en         = bus_wdata[0];
        if (strb.time_lo_wr) st_d.time_stage = bus_wdata;
        if (strb.step_lo_wr) st_d.step_stage = bus_wdata;

        // Step: a bus commit outranks a speed default
        if (strb.step_hi_wr)
            st_d.step = {bus_wdata[STEP_HI_W-1:0], st_q.step_stage};
        else if (speed_apply)
            st_d.step = dflt_step;

        // Time: a load replaces the stepped value for this edge
        if (strb.time_hi_wr) begin
            st_d.ns   = {bus_wdata[TIME_HI_W-1:0], st_q.time_stage};
            st_d.frac = '0;
        end else if (st_q.en) begin
            st_d.ns   = step_ns;
            st_d.frac = step_frac;
        end

        if (strb.time_lo_rd) st_d.snap = st_q.ns[TIME_W-1:BUS_W];

        if (bus_rd) begin
            unique case (bus_addr)
                REG_CTRL:    st_d.rdata = BUS_W'(st_q.en);
                REG_TIME_LO: st_d.rdata = st_q.ns[BUS_W-1:0];
                REG_TIME_HI: st_d.rdata = BUS_W'(st_q.snap);
                REG_STEP_LO: st_d.rdata = st_q.step[BUS_W-1:0];
                REG_STEP_HI: st_d.rdata = BUS_W'(st_q.step[STEP_W-1:BUS_W]);
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign tod_ns    = st_q.ns;

endmodule

// File: rtl/tod_ns_counter_chk.sv
`timescale 1ns/1ps
module tod_ns_counter_chk #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned STEP_W = 64,
    parameter int unsigned BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [TIME_W-1:0] ns,
    input logic [STEP_W-1:0] step,
    input logic              time_load,
    input logic              step_lo_wr,
    input logic              step_hi_wr,
    input logic              speed_apply,
    input logic              ctrl_rd,
    input logic [BUS_W-1:0]  time_stage,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata
);
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !time_load) |=> $stable(ns));

    p_zero_step_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0 && !time_load) |=> $stable(ns));

    p_never_backwards_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !time_load) |=> (ns >= $past(ns)));

    p_load_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        time_load |=> (ns == {$past(bus_wdata), $past(time_stage)}));

    p_step_lo_staged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_lo_wr && !step_hi_wr && !speed_apply) |=> $stable(step));

    p_ctrl_readback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (bus_rdata == BUS_W'($past(en))));
endmodule

bind tod_ns_counter tod_ns_counter_chk #(
    .TIME_W (TIME_W),
    .STEP_W (STEP_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (st_q.en),
    .ns          (st_q.ns),
    .step        (st_q.step),
    .time_load   (strb.time_hi_wr),
    .step_lo_wr  (strb.step_lo_wr),
    .step_hi_wr  (strb.step_hi_wr),
    .speed_apply (speed_apply),
    .ctrl_rd     (bus_rd && (bus_addr == 3'd0)),
    .time_stage  (st_q.time_stage),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata)
);

// File: tb/tod_ns_counter_tb.sv
`timescale 1ns/1ps
module tod_ns_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  speed_sel = 2'd0;
    logic        speed_apply = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [63:0] tod_ns;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tod_ns_counter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_sel   (speed_sel),
        .speed_apply (speed_apply),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tod_ns      (tod_ns)
    );

    function automatic logic [63:0] spd_step(input int code);
        case (code)
            0: return 64'h0000_0001_9999_9999;
            1: return 64'h0000_0003_3333_3333;
            2: return 64'h0000_0020_0000_0000;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] after_k(input logic [63:0] t0, input logic [63:0] st, input int k);
        logic [127:0] prod;
        prod = 128'(k) * 128'(st);
        return t0 + prod[95:32];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(3'd1, lo);
        rd(3'd2, hi);
        t = {hi, lo};
    endtask

    task automatic rd_step(output logic [63:0] s);
        logic [31:0] lo, hi;
        rd(3'd3, lo);
        rd(3'd4, hi);
        s = {hi, lo};
    endtask

    task automatic load_time(input logic [63:0] t);
        wr(3'd1, t[31:0]);
        wr(3'd2, t[63:32]);
    endtask

    task automatic apply_speed(input int code);
        speed_sel = 2'(code); speed_apply = 1'b1;
        @(negedge clk);
        speed_apply = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [63:0] t, s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, w);     check("R1 ctrl", 64'(w), 64'h0);
        rd_step(s);      check("R1 step", s, 64'h0000_0001_9999_9999);
        rd_time(t);      check("R1 time", t, 64'h0);

        // R3 frozen while disabled
        load_time(64'h0000_00AB_0000_1000);
        repeat (10) @(negedge clk);
        rd_time(t);      check("R3 frozen", t, 64'h0000_00AB_0000_1000);
        check("R3 tod_ns port", tod_ns, 64'h0000_00AB_0000_1000);

        // R7 time-low write only stages
        wr(3'd1, 32'h0000_0099);
        rd_time(t);      check("R7 staged", t, 64'h0000_00AB_0000_1000);
        wr(3'd2, 32'h0000_0000);
        rd_time(t);      check("R8 load", t, 64'h0000_0000_0000_0099);

        // R12 control readback and unmapped address
        wr(3'd0, 32'h1);
        rd(3'd0, w);     check("R12 ctrl", 64'(w), 64'h1);
        rd(3'd7, w);     check("R12 unmapped", 64'(w), 64'h0);
        @(negedge clk);
        check("R12 hold", 64'(bus_rdata), 64'h0);

        // R2/R4 sweep over speed codes and edge counts
        for (int c = 0; c < 4; c++) begin
            apply_speed(c);
            rd_step(s);  check("R4 default step", s, spd_step(c));
            for (int k = 0; k < 20; k++) begin
                load_time(64'h0000_0012_3456_0000 + 64'(k));
                repeat (k) @(negedge clk);
                rd_time(t);
                check((c == 3) ? "R5 zero step" : "R2 count",
                      t, after_k(64'h0000_0012_3456_0000 + 64'(k), spd_step(c), k));
            end
        end

        // R6 latch across a 32-bit rollover
        apply_speed(2);
        load_time(64'h0000_0001_FFFF_FFF0);
        rd(3'd1, w);     check("R6 low word", 64'(w), 64'hFFFF_FFF0);
        repeat (4) @(negedge clk);
        rd(3'd2, w);     check("R6 latched high", 64'(w), 64'h1);

        // R8 fraction cleared on load (step 0.9375 ns)
        wr(3'd3, 32'hF000_0000);
        wr(3'd4, 32'h0);
        load_time(64'h500);
        @(negedge clk);
        rd_time(t);      check("R8 first", t, 64'h500);
        load_time(64'h500);
        @(negedge clk);
        rd_time(t);      check("R8 fraction cleared", t, 64'h500);

        // R9 step staging
        wr(3'd3, 32'h1234_5678);
        rd_step(s);      check("R9 staged", s, 64'h0000_0000_F000_0000);
        wr(3'd4, 32'h2);
        rd_step(s);      check("R9 commit", s, 64'h0000_0002_1234_5678);

        // R10 time load and step change on one edge
        apply_speed(0);
        wr(3'd1, 32'h0000_4000);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h7;
        speed_sel = 2'd2; speed_apply = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; speed_apply = 1'b0;
        repeat (3) @(negedge clk);
        rd_time(t);      check("R10 same edge", t, 64'h0000_0007_0000_4000 + 64'd96);
        rd_step(s);      check("R10 step applied", s, 64'h0000_0020_0000_0000);

        // R11 bus commit outranks speed default
        wr(3'd3, 32'h0);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h7;
        speed_sel = 2'd1; speed_apply = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; speed_apply = 1'b0;
        rd_step(s);      check("R11 bus wins", s, 64'h0000_0007_0000_0000);

        // R3 disable again stops counting
        wr(3'd0, 32'h0);
        load_time(64'h77);
        repeat (5) @(negedge clk);
        rd_time(t);      check("R3 disabled again", t, 64'h77);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule